// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block finds the first Ethernet PHY attached to a management bus. After a start pulse it walks every management address from the lowest to the highest. For each address it asks an MDIO frame engine to read the two identifier registers, and it stops at the first address whose identifier pair looks like a real device. The frame engine sits behind a request/response port and handles all serial timing. This block only sequences the reads and judges what comes back.

At the end of a scan it raises a one-cycle done pulse. At that point it reports:

- whether a PHY was found,
- the address where it was found,
- both identifier words,
- a small kind code that recognises two known integrated PHY signatures and marks any other device as unknown.

The results stay unchanged until the next start. Software or a bring-up sequencer then uses the address for all later management accesses.

Top module: `phy_probe_scan`

## Requirements
- R1: Candidate addresses are probed strictly in ascending order, starting at 0 and ending no later than 31. A new scan always restarts at address 0.
- R2: For each candidate, register number 2 (the high identifier word) is requested first and register number 3 (the low identifier word) second. Both are always read, so a scan that finds nothing issues exactly 64 reads and one that stops at address N issues 2*(N+1).
- R3: A candidate is accepted only if both of its words are strictly above 0x0000 and strictly below 0xFFFF. The values 0x0001 and 0xFFFE are accepted.
- R4: A candidate is rejected when either word equals 0x8000.
- R5: The scan stops at the first accepted address and issues no further reads. `found` goes to 1, `phy_addr` holds that address, `id_hi` holds the register-2 word and `id_lo` holds the register-3 word.
- R6: When all 32 candidates are rejected, `found` is 0 and `phy_addr`, `id_hi` and `id_lo` read 0.
- R7: `phy_kind` is 1 when `id_hi` = 0x0016 and (`id_lo` & 0xFFF0) = 0xF840. It is 2 when `id_hi` = 0x0282 and (`id_lo` & 0xFFF0) = 0x1C50. It is 0 for any other accepted PHY and whenever `found` is 0.
- R8: `done` is high for exactly one clock. It rises in the cycle after the response to the final read. The result outputs change together with the rise of `done`, and then hold their values until the next accepted start.
- R9: `start` is ignored while `busy` is high. `busy` is low in the `done` cycle, so a start in that cycle is accepted: the results clear to zero on the next edge and a new scan begins.
- R10: `req_valid`, `req_addr` and `req_reg` stay stable until `rsp_done` is seen. A `rsp_done` that arrives while no request is outstanding has no effect.
- R11: After reset, `busy`, `done`, `req_valid` and `found` are 0 and the results read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| req_valid | output | 1 | Read request to the frame engine, held until answered |
| req_addr | output | 5 | PHY address of the current request |
| req_reg | output | 5 | Register number of the current request (2 or 3) |
| rsp_done | input | 1 | One-cycle completion from the frame engine |
| rsp_data | input | 16 | Read data, valid with rsp_done |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A plausible PHY was located |
| phy_addr | output | 5 | Address of the located PHY |
| id_hi | output | 16 | Identifier word from register 2 |
| id_lo | output | 16 | Identifier word from register 3 |
| phy_kind | output | 2 | 0 unknown/none, 1 first known signature, 2 second known signature |

## Verification
The end-of-scan pulse and the acceptance of a new start can land in the same cycle, because `busy` has already dropped when `done` rises. The bench raises `start` in exactly the cycle in which it sees `done`. In that cycle it checks that the old results are still shown. One cycle later it checks that the scanner is busy, the results have cleared and `done` is low. It then lets the new scan run to completion and checks its result and its read order against the model.

// File: rtl/phy_scan_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the PHY address scanner.
// Assumes 16-bit management registers and 5-bit PHY/register addresses.
package phy_scan_pkg;

    localparam int ID_W   = 16;
    localparam int ADDR_W = 5;
    localparam int REG_W  = 5;

    // Identifier registers read for every candidate, in this order.
    localparam logic [REG_W-1:0] REG_ID_HI = 5'd2;
    localparam logic [REG_W-1:0] REG_ID_LO = 5'd3;

    // Words that mark an absent or broken responder.
    localparam logic [ID_W-1:0] WORD_NONE  = '0;
    localparam logic [ID_W-1:0] WORD_FLOAT = '1;
    localparam logic [ID_W-1:0] WORD_MSB   = 16'h8000;

    // Low nibble of the low word is a revision and is ignored for typing.
    localparam logic [ID_W-1:0] REV_MASK = 16'hFFF0;

    typedef enum logic [1:0] {
        KIND_UNKNOWN = 2'd0,
        KIND_SIG_A   = 2'd1,
        KIND_SIG_B   = 2'd2
    } phy_kind_e;

    localparam int NUM_SIG = 2;
    localparam logic [ID_W-1:0] SIG_HI   [NUM_SIG] = '{16'h0016, 16'h0282};
    localparam logic [ID_W-1:0] SIG_LO   [NUM_SIG] = '{16'hF840, 16'h1C50};
    localparam phy_kind_e       SIG_KIND [NUM_SIG] = '{KIND_SIG_A, KIND_SIG_B};

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_HI = 3'd1,
        ST_RD_LO = 3'd2,
        ST_EVAL  = 3'd3
    } scan_state_e;

endpackage

// File: rtl/phy_id_judge.sv
`timescale 1ns/1ps
// Module: phy_id_judge
// Purely combinational judgement of an identifier pair.
// - plausible: both words are neither all-zero, all-one, nor 0x8000.
// - kind: which known signature (high word equal, low word equal after
//   the revision nibble is masked off) matches, else unknown.
// Assumes kind is only consumed together with plausible.
module phy_id_judge
    import phy_scan_pkg::*;
(
    input  logic [ID_W-1:0] hi_word,
    input  logic [ID_W-1:0] lo_word,
    output logic            plausible,
    output phy_kind_e       kind
);

    logic hi_ok;
    logic lo_ok;
    logic [NUM_SIG-1:0] sig_hit;

    // Range and sentinel screening of each word.
    always_comb begin
        hi_ok = (hi_word != WORD_NONE) && (hi_word != WORD_FLOAT) && (hi_word != WORD_MSB);
        lo_ok = (lo_word != WORD_NONE) && (lo_word != WORD_FLOAT) && (lo_word != WORD_MSB);
        plausible = hi_ok && lo_ok;
    end

    // One comparator pair per known signature.
    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
        assign sig_hit[s] = (hi_word == SIG_HI[s]) && ((lo_word & REV_MASK) == SIG_LO[s]);
    end

    // Lowest-numbered matching signature wins.
    always_comb begin
        kind = KIND_UNKNOWN;
        for (int s = NUM_SIG - 1; s >= 0; s--) begin
            if (sig_hit[s]) kind = SIG_KIND[s];
        end
    end

endmodule

// File: rtl/phy_scan_fsm.sv
`timescale 1ns/1ps
// Module: phy_scan_fsm
// Sequences the scan: for each candidate address it issues a read of the
// high identifier register, then the low one, holds both words, and spends
// one evaluation cycle on the verdict from the judge.
// Assumes the frame engine answers each held request with one rsp_done pulse.
module phy_scan_fsm
    import phy_scan_pkg::*;
#(
    parameter int NUM_ADDR = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rsp_done,
    input  logic [ID_W-1:0]   rsp_data,
    input  logic              plausible,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [REG_W-1:0]  req_reg,
    output logic              busy,
    output logic              done,
    output logic              clear,
    output logic              accept,
    output logic [ID_W-1:0]   hi_word,
    output logic [ID_W-1:0]   lo_word
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_ADDR - 1);

    scan_state_e       state_q;
    logic [ADDR_W-1:0] cand_q;
    logic [ID_W-1:0]   hi_q;
    logic [ID_W-1:0]   lo_q;
    logic              done_q;
    logic              last_cand;

    assign last_cand = (cand_q == LAST_ADDR);

    // State, candidate counter, word capture and end-of-scan pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cand_q  <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cand_q  <= '0;
                        state_q <= ST_RD_HI;
                    end
                end
                ST_RD_HI: begin
                    if (rsp_done) begin
                        hi_q    <= rsp_data;
                        state_q <= ST_RD_LO;
                    end
                end
                ST_RD_LO: begin
                    if (rsp_done) begin
                        lo_q    <= rsp_data;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (plausible || last_cand) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cand_q  <= cand_q + 1'b1;
                        state_q <= ST_RD_HI;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request port and strobes toward the result holder.
    always_comb begin
        req_valid = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
        req_addr  = cand_q;
        req_reg   = (state_q == ST_RD_LO) ? REG_ID_LO : REG_ID_HI;
        busy      = (state_q != ST_IDLE);
        clear     = (state_q == ST_IDLE) && start;
        accept    = (state_q == ST_EVAL) && plausible;
        done      = done_q;
        hi_word   = hi_q;
        lo_word   = lo_q;
    end

    // R10: an unanswered request keeps its address and register.
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_done) |=> (req_valid && $stable(req_addr) && $stable(req_reg)));

    // R1: during a scan the candidate never moves downward.
    a_r1_addr_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (req_addr >= $past(req_addr)));

    // R8: the end-of-scan pulse lasts one clock.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: when done is high the scanner is already free for a new start.
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/phy_scan_result.sv
`timescale 1ns/1ps
// Module: phy_scan_result
// Holds the visible scan outcome. Cleared when a scan is accepted, loaded
// once when a plausible candidate is accepted, otherwise held.
// Assumes clear and load never coincide (they come from different states).
module phy_scan_result
    import phy_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              done,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic [ID_W-1:0]   hi_word,
    input  logic [ID_W-1:0]   lo_word,
    input  phy_kind_e         kind_in,
    output logic              found,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [ID_W-1:0]   id_hi,
    output logic [ID_W-1:0]   id_lo,
    output phy_kind_e         phy_kind
);

    // Result registers: reset/clear to zero, load on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            found    <= 1'b0;
            phy_addr <= '0;
            id_hi    <= '0;
            id_lo    <= '0;
            phy_kind <= KIND_UNKNOWN;
        end else if (load) begin
            found    <= 1'b1;
            phy_addr <= cand_addr;
            id_hi    <= hi_word;
            id_lo    <= lo_word;
            phy_kind <= kind_in;
        end
    end

    // R3: a reported PHY never carries an all-zero or all-one word.
    a_r3_found_words_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (id_hi != WORD_NONE && id_hi != WORD_FLOAT &&
                   id_lo != WORD_NONE && id_lo != WORD_FLOAT));

    // R4: a reported PHY never carries the 0x8000 sentinel.
    a_r4_found_no_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (id_hi != WORD_MSB && id_lo != WORD_MSB));

    // R7: no kind is reported without a found PHY.
    a_r7_kind_needs_found: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (phy_kind == KIND_UNKNOWN));

    // R8: results appear together with the end-of-scan pulse.
    a_r8_found_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> done);

endmodule

// File: rtl/phy_probe_scan.sv
`timescale 1ns/1ps
// Module: phy_probe_scan (top)
// Scans management addresses for the first PHY with a plausible identifier
// pair, reports its address, identifiers and a signature kind.
// Assumes an MDIO frame engine behind req_*/rsp_* handling serial timing.
module phy_probe_scan
    import phy_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        req_valid,
    output logic [4:0]  req_addr,
    output logic [4:0]  req_reg,
    input  logic        rsp_done,
    input  logic [15:0] rsp_data,
    output logic        busy,
    output logic        done,
    output logic        found,
    output logic [4:0]  phy_addr,
    output logic [15:0] id_hi,
    output logic [15:0] id_lo,
    output logic [1:0]  phy_kind
);

    logic            clear;
    logic            accept;
    logic            plausible;
    logic [ID_W-1:0] hi_word;
    logic [ID_W-1:0] lo_word;
    phy_kind_e       kind_w;
    phy_kind_e       kind_q;

    phy_scan_fsm #(
        .NUM_ADDR (1 << ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data),
        .plausible (plausible),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_reg   (req_reg),
        .busy      (busy),
        .done      (done),
        .clear     (clear),
        .accept    (accept),
        .hi_word   (hi_word),
        .lo_word   (lo_word)
    );

    phy_id_judge u_judge (
        .hi_word   (hi_word),
        .lo_word   (lo_word),
        .plausible (plausible),
        .kind      (kind_w)
    );

    phy_scan_result u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .load      (accept),
        .done      (done),
        .cand_addr (req_addr),
        .hi_word   (hi_word),
        .lo_word   (lo_word),
        .kind_in   (kind_w),
        .found     (found),
        .phy_addr  (phy_addr),
        .id_hi     (id_hi),
        .id_lo     (id_lo),
        .phy_kind  (kind_q)
    );

    assign phy_kind = kind_q;

endmodule

// File: tb/tb_phy_probe_scan.sv
`timescale 1ns/1ps
// Bench: a behavioural frame engine answers reads from a 32-entry model of
// identifier words; a vector table sets one device per scan, followed by
// directed reset, ordering, restart and overlap cases.
module tb_phy_probe_scan;

    localparam int LAT  = 2;
    localparam int NVEC = 12;
    // {addr[4:0], hi[15:0], lo[15:0], found, kind[1:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {5'd0,  16'h0016, 16'hF843, 1'b1, 2'd1},
        {5'd5,  16'h0282, 16'h1C5F, 1'b1, 2'd2},
        {5'd31, 16'h1234, 16'h5678, 1'b1, 2'd0},
        {5'd7,  16'h8000, 16'h1234, 1'b0, 2'd0},
        {5'd7,  16'h1234, 16'h8000, 1'b0, 2'd0},
        {5'd3,  16'h0000, 16'h1234, 1'b0, 2'd0},
        {5'd3,  16'h1234, 16'hFFFF, 1'b0, 2'd0},
        {5'd9,  16'h0001, 16'hFFFE, 1'b1, 2'd0},
        {5'd12, 16'h0016, 16'hF850, 1'b1, 2'd0},
        {5'd20, 16'h0283, 16'h1C50, 1'b1, 2'd0},
        {5'd2,  16'h0016, 16'hF84F, 1'b1, 2'd1},
        {5'd14, 16'hFFFF, 16'h1234, 1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid;
    logic [4:0]  req_addr;
    logic [4:0]  req_reg;
    logic        rsp_done = 1'b0;
    logic [15:0] rsp_data = 16'h0;
    logic        busy;
    logic        done;
    logic        found;
    logic [4:0]  phy_addr;
    logic [15:0] id_hi;
    logic [15:0] id_lo;
    logic [1:0]  phy_kind;

    int checks = 0;
    int errors = 0;

    logic [15:0] mhi [32];
    logic [15:0] mlo [32];

    // Responder bookkeeping, owned by the responder process.
    logic        track_clr = 1'b0;
    logic        spur = 1'b0;
    bit          pend = 0;
    int          cnt = 0;
    logic [4:0]  cur_a = '0;
    logic [4:0]  cur_r = '0;
    int          reads = 0;
    bit          order_bad = 0;
    logic [4:0]  exp_a = '0;
    logic [4:0]  exp_r = 5'd2;

    always #2 clk = ~clk;

    phy_probe_scan dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_reg   (req_reg),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data),
        .busy      (busy),
        .done      (done),
        .found     (found),
        .phy_addr  (phy_addr),
        .id_hi     (id_hi),
        .id_lo     (id_lo),
        .phy_kind  (phy_kind)
    );

    // Behavioural frame engine with fixed latency and order tracking.
    always @(negedge clk) begin
        if (track_clr) begin
            reads = 0; order_bad = 0; exp_a = '0; exp_r = 5'd2;
        end
        if (spur) begin
            rsp_done = 1'b1; rsp_data = 16'hBEEF;
        end else if (rsp_done) begin
            rsp_done = 1'b0; pend = 0;
        end else if (pend) begin
            if (cnt == 0) begin
                rsp_done = 1'b1;
                rsp_data = (cur_r == 5'd2) ? mhi[cur_a] : (cur_r == 5'd3) ? mlo[cur_a] : 16'h0;
            end else cnt--;
        end else if (req_valid) begin
            pend = 1; cnt = LAT; cur_a = req_addr; cur_r = req_reg;
            if (req_addr != exp_a || req_reg != exp_r) order_bad = 1;
            reads++;
            if (exp_r == 5'd2) exp_r = 5'd3;
            else begin exp_r = 5'd2; exp_a = exp_a + 5'd1; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic model_absent;
        for (int i = 0; i < 32; i++) begin mhi[i] = 16'hFFFF; mlo[i] = 16'hFFFF; end
    endtask

    task automatic pulse_start;
        start = 1'b1; track_clr = 1'b1;
        tick();
        start = 1'b0; track_clr = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin ok = 1; return; end
            tick();
        end
        chk("watchdog done", 32'd0, 32'd1);
    endtask

    task automatic check_result(input string tag, input logic [4:0] a, input logic [15:0] h,
                                input logic [15:0] l, input bit f, input logic [1:0] k);
        chk({tag, " R5 R6 found"}, {31'd0, found}, {31'd0, f});
        chk({tag, " R5 R6 addr"}, {27'd0, phy_addr}, f ? {27'd0, a} : 32'd0);
        chk({tag, " R5 R6 id_hi"}, {16'd0, id_hi}, f ? {16'd0, h} : 32'd0);
        chk({tag, " R5 R6 id_lo"}, {16'd0, id_lo}, f ? {16'd0, l} : 32'd0);
        chk({tag, " R7 kind"}, {30'd0, phy_kind}, {30'd0, k});
        chk({tag, " R2 reads"}, reads, f ? 2 * (a + 1) : 64);
        chk({tag, " R1 R2 order"}, {31'd0, order_bad}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        model_absent();
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R11: reset state
        chk("R11 busy", {31'd0, busy}, 0);
        chk("R11 done", {31'd0, done}, 0);
        chk("R11 req_valid", {31'd0, req_valid}, 0);
        chk("R11 found", {31'd0, found}, 0);
        chk("R11 ids", {id_hi, id_lo}, 0);

        // Table walk: one device per scan (R3 R4 R5 R6 R7)
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0] a; logic [15:0] h; logic [15:0] l; bit f; logic [1:0] k;
            {a, h, l, f, k} = VEC[v];
            model_absent();
            mhi[a] = h; mlo[a] = l;
            pulse_start();
            wait_done(ok);
            check_result($sformatf("vec%0d", v), a, h, l, f, k);
        end

        // R8: one-cycle done, results held afterwards
        tick();
        chk("R8 done width", {31'd0, done}, 0);
        repeat (10) tick();
        chk("R8 hold addr", {27'd0, phy_addr}, 32'd0);
        chk("R8 hold found", {31'd0, found}, 0);

        // R5: two devices, stop at the lower one
        model_absent();
        mhi[4] = 16'h0282; mlo[4] = 16'h1C51;
        mhi[10] = 16'h0016; mlo[10] = 16'hF840;
        pulse_start();
        wait_done(ok);
        check_result("two devs", 5'd4, 16'h0282, 16'h1C51, 1'b1, 2'd2);
        repeat (10) tick();
        chk("R5 no reads after stop", reads, 10);

        // R10: stray rsp_done while idle has no effect
        spur = 1'b1; tick(); spur = 1'b0;
        repeat (3) tick();
        chk("R10 stray busy", {31'd0, busy}, 0);
        chk("R10 stray done", {31'd0, done}, 0);
        chk("R10 stray ids", {id_hi, id_lo}, {16'h0282, 16'h1C51});
        chk("R10 stray req", {31'd0, req_valid}, 0);

        // R9: start while busy ignored
        model_absent();
        mhi[10] = 16'h0ABC; mlo[10] = 16'h0DEF;
        pulse_start();
        repeat (30) tick();
        start = 1'b1; tick(); start = 1'b0;
        wait_done(ok);
        check_result("R9 restart ignored", 5'd10, 16'h0ABC, 16'h0DEF, 1'b1, 2'd0);
        tick();
        repeat (40) begin
            if (done) chk("R9 extra done", 1, 0);
            tick();
        end

        // R9 R8: start in the same cycle as done
        model_absent();
        mhi[1] = 16'h0016; mlo[1] = 16'hF84A;
        pulse_start();
        wait_done(ok);
        chk("R9 overlap done seen", {31'd0, done}, 1);
        chk("R9 overlap old found", {31'd0, found}, 1);
        mhi[1] = 16'hFFFF; mlo[1] = 16'hFFFF;
        mhi[6] = 16'h0282; mlo[6] = 16'h1C50;
        start = 1'b1; track_clr = 1'b1;
        tick();
        start = 1'b0; track_clr = 1'b0;
        chk("R9 overlap busy", {31'd0, busy}, 1);
        chk("R9 overlap cleared", {31'd0, found}, 0);
        chk("R9 overlap done low", {31'd0, done}, 0);
        wait_done(ok);
        check_result("R9 overlap rescan", 5'd6, 16'h0282, 16'h1C50, 1'b1, 2'd2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule